// File: doc/BRIEF.md
# Debounced Alarm Tone Generator

This block turns a mechanical alarm switch into a drive signal for an external speaker transistor. The raw switch level is brought into the clock domain, sampled on a slow tick and accepted only after it has held steady for a window of roughly 23 to 31 ms. Shorter bounces and glitches are dropped. While the accepted alarm state is active, the output carries a square-wave tone carrier. A slower square wave gates the carrier, and a long on/off burst pattern gates the result again.

All rates are set by parameters as integer divisions of a 32768 Hz clock. These are the carrier, the modulation, the debounce sampling rate and the number of agreeing samples, together with the burst on and off lengths in clock cycles. Two bit parameters choose which switch level means "alarm". They also choose the idle level of the output, which suits either an npn stage (idle low) or a pnp stage (idle high).

When the alarm is accepted, the pattern starts at cycle zero of an on burst, in the enabled half of the modulation and the driven half of the carrier. When the release is accepted, the output returns to idle in the same cycle and every timing counter is cleared.

Top module: `alarm_tone_gen`

## Requirements
- R1: During reset and after it, with the switch held inactive, the output stays at its idle level.
- R2: A switch activation is accepted after DEB_SAMPLES consecutive tick samples (tick period P = CLK_HZ/DEB_HZ cycles) disagree with the accepted state. The first driven output cycle comes between (DEB_SAMPLES-1)*P+1 and DEB_SAMPLES*P+3 clock cycles after the switch change.
- R3: A switch pulse shorter than (DEB_SAMPLES-1)*P clock cycles is ignored, and the output stays idle.
- R4: SW_ACTIVE_HIGH selects the switch level that means alarm. With 0, a low switch level activates, and the timing is identical to the active-high case.
- R5: Let t count the cycles from the first driven cycle. Inside an on burst and the enabled modulation half, the carrier is driven for TONE_HALF = CLK_HZ/(2*TONE_HZ) cycles and idle for TONE_HALF cycles, starting driven at t=0.
- R6: The modulation alternates MOD_HALF = CLK_HZ/(2*MOD_HZ) cycles enabled and MOD_HALF cycles silenced, starting enabled at t=0. While silenced, the output is idle.
- R7: Bursts alternate ON_CYC cycles on and OFF_CYC cycles off, starting on at t=0. During off, the output is idle. The carrier and modulation keep counting across bursts.
- R8: After a release is accepted, the output is idle. A later activation restarts the whole pattern at t=0.
- R9: OUT_IDLE_HIGH sets the idle output level. The driven carrier level is its complement.
- R10: While the alarm is active, a release pulse shorter than (DEB_SAMPLES-1)*P cycles does not disturb the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32768 Hz timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_sw_i | input | 1 | Raw, asynchronous alarm switch level |
| alarm_drv_o | output | 1 | Drive for the external speaker transistor |

## Verification
The hardest situation to reach from the ports is a release glitch arriving while the alarm is active and the pattern is mid-burst. A missed rejection shows up only as a shifted or restarted pattern, not as a stuck output. The bench reaches it by pulsing the switch inactive for a little more than one tick period, partway through the first on burst. It keeps comparing every output cycle against a pattern model built from the burst, modulation and carrier formulas. Any restart or gap then shows as a mismatch in a later burst.

// File: rtl/alarm_tone_pkg.sv
package alarm_tone_pkg;

  // Half period, in clock cycles, of a square wave at f_hz.
  function automatic int half_period(input int clk_hz, input int f_hz);
    return clk_hz / (2 * f_hz);
  endfunction

  // Full period, in clock cycles, of a tick at f_hz.
  function automatic int tick_period(input int clk_hz, input int f_hz);
    return clk_hz / f_hz;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/alarm_debounce.sv
module alarm_debounce
  import alarm_tone_pkg::*;
#(
  parameter int PERIOD      = 256,
  parameter int SAMPLES     = 4,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_raw_i,
  output logic active_o,
  output logic tick_o
);
  localparam int PW = cnt_width(PERIOD);
  localparam int AW = cnt_width(SAMPLES);
  localparam logic [PW-1:0] PRE_LAST   = PW'(PERIOD - 1);
  localparam logic [AW-1:0] AGREE_LAST = AW'(SAMPLES - 1);
  localparam logic RAW_IDLE = ~ACTIVE_HIGH;

  logic [1:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic [AW-1:0] agree_q;
  logic          level;

  // two-flop synchronizer for the asynchronous switch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {2{RAW_IDLE}};
    else         sync_q <= {sync_q[0], sw_raw_i};
  end

  assign level  = ACTIVE_HIGH ? sync_q[1] : ~sync_q[1];
  assign tick_o = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // count consecutive disagreeing samples; flip after SAMPLES of them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agree_q  <= '0;
      active_o <= 1'b0;
    end else if (tick_o) begin
      if (level == active_o) begin
        agree_q <= '0;
      end else if (agree_q == AGREE_LAST) begin
        agree_q  <= '0;
        active_o <= level;
      end else begin
        agree_q <= agree_q + 1'b1;
      end
    end
  end

  p_accept_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_o) |-> $past(tick_o));

  p_reject_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_o) |-> $past(agree_q) == AGREE_LAST);

endmodule

// File: rtl/alarm_square_div.sv
module alarm_square_div
  import alarm_tone_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o
);
  localparam int W = cnt_width(HALF);
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt_q;

  // phase 1 = enabled/driven half; held at 1 and count cleared while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_half_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(phase_o)) |-> $past(cnt_q) == LAST);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_o && cnt_q == '0));

endmodule

// File: rtl/alarm_burst_gate.sv
module alarm_burst_gate
  import alarm_tone_pkg::*;
#(
  parameter int ON_CYC  = 32768,
  parameter int OFF_CYC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic on_o
);
  localparam int W = cnt_width(max2(ON_CYC, OFF_CYC));
  localparam logic [W-1:0] ON_LAST  = W'(ON_CYC - 1);
  localparam logic [W-1:0] OFF_LAST = W'(OFF_CYC - 1);

  logic [W-1:0] cnt_q;
  logic         last;

  assign last = on_o ? (cnt_q == ON_LAST) : (cnt_q == OFF_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_o  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      on_o  <= 1'b1;
    end else if (last) begin
      cnt_q <= '0;
      on_o  <= ~on_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_on_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $fell(on_o)) |-> $past(cnt_q) == ON_LAST);

  p_off_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $rose(on_o)) |-> $past(cnt_q) == OFF_LAST);

endmodule

// File: rtl/alarm_tone_gen.sv
module alarm_tone_gen
  import alarm_tone_pkg::*;
#(
  parameter int CLK_HZ         = 32768,
  parameter int DEB_HZ         = 128,
  parameter int DEB_SAMPLES    = 4,
  parameter int TONE_HZ        = 2048,
  parameter int MOD_HZ         = 8,
  parameter int ON_CYC         = 32768,
  parameter int OFF_CYC        = 32768,
  parameter bit SW_ACTIVE_HIGH = 1'b1,
  parameter bit OUT_IDLE_HIGH  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_sw_i,
  output logic alarm_drv_o
);
  localparam int DEB_PERIOD = tick_period(CLK_HZ, DEB_HZ);
  localparam int TONE_HALF  = half_period(CLK_HZ, TONE_HZ);
  localparam int MOD_HALF   = half_period(CLK_HZ, MOD_HZ);
  localparam int DIV_HALF [2] = '{TONE_HALF, MOD_HALF};
  localparam logic IDLE = OUT_IDLE_HIGH;

  // named internal events
  logic       alarm_act;
  logic       deb_tick;
  logic       burst_on;
  logic [1:0] div_ph;     // [0] carrier, [1] modulation
  logic       drive;

  alarm_debounce #(
    .PERIOD     (DEB_PERIOD),
    .SAMPLES    (DEB_SAMPLES),
    .ACTIVE_HIGH(SW_ACTIVE_HIGH)
  ) u_debounce (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_raw_i(alarm_sw_i),
    .active_o(alarm_act),
    .tick_o  (deb_tick)
  );

  for (genvar g = 0; g < 2; g++) begin : g_div
    alarm_square_div #(.HALF(DIV_HALF[g])) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (alarm_act),
      .phase_o(div_ph[g])
    );
  end

  alarm_burst_gate #(
    .ON_CYC (ON_CYC),
    .OFF_CYC(OFF_CYC)
  ) u_burst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (alarm_act),
    .on_o  (burst_on)
  );

  assign drive       = alarm_act & burst_on & div_ph[1] & div_ph[0];
  assign alarm_drv_o = drive ? ~IDLE : IDLE;

  p_first_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_act) |-> alarm_drv_o != IDLE);

  p_accept_at_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_act) |-> $past(deb_tick));

endmodule

// File: tb/alarm_tone_gen_bench.sv
`timescale 1ns/1ps
module alarm_tone_gen_bench;
  localparam int CLK_HZ  = 32768;
  localparam int DEB_HZ  = 2048;   // P = 16 cycles
  localparam int NSAMP   = 4;
  localparam int TONE_HZ = 2048;   // half = 8
  localparam int MOD_HZ  = 256;    // half = 64
  localparam int ON_C    = 384;
  localparam int OFF_C   = 256;
  localparam int P       = CLK_HZ / DEB_HZ;
  localparam int TH      = CLK_HZ / (2 * TONE_HZ);
  localparam int MH      = CLK_HZ / (2 * MOD_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0;
  logic sw_n;
  logic out_a, out_b;
  int   errs = 0;
  int   chks = 0;

  always #2 clk = ~clk;
  assign sw_n = ~sw;

  alarm_tone_gen #(.CLK_HZ(CLK_HZ), .DEB_HZ(DEB_HZ), .DEB_SAMPLES(NSAMP),
    .TONE_HZ(TONE_HZ), .MOD_HZ(MOD_HZ), .ON_CYC(ON_C), .OFF_CYC(OFF_C),
    .SW_ACTIVE_HIGH(1'b1), .OUT_IDLE_HIGH(1'b0)) u_alarm_tone_gen (
    .clk_i(clk), .rst_ni(rst_n), .alarm_sw_i(sw), .alarm_drv_o(out_a));

  alarm_tone_gen #(.CLK_HZ(CLK_HZ), .DEB_HZ(DEB_HZ), .DEB_SAMPLES(NSAMP),
    .TONE_HZ(TONE_HZ), .MOD_HZ(MOD_HZ), .ON_CYC(ON_C), .OFF_CYC(OFF_C),
    .SW_ACTIVE_HIGH(1'b0), .OUT_IDLE_HIGH(1'b1)) u_alarm_tone_gen_inv (
    .clk_i(clk), .rst_ni(rst_n), .alarm_sw_i(sw_n), .alarm_drv_o(out_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pattern model: 1 when the carrier is in its driven level at time t
  function automatic bit model_drive(input int t);
    bit on, md, cr;
    on = (t % (ON_C + OFF_C)) < ON_C;
    md = ((t / MH) % 2) == 0;
    cr = ((t / TH) % 2) == 0;
    return on && md && cr;
  endfunction

  task automatic t_reset();
    int bad_a = 0, bad_b = 0;
    repeat (3) @(negedge clk);
    check(out_a == 1'b0, "R1 idle in reset (npn)", out_a, 0);
    check(out_b == 1'b1, "R1 R9 idle in reset (pnp)", out_b, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (out_a != 1'b0) bad_a++;
      if (out_b != 1'b1) bad_b++;
    end
    check(bad_a == 0, "R1 idle after reset, cycles driven", bad_a, 0);
    check(bad_b == 0, "R1 R9 idle high after reset, cycles driven", bad_b, 0);
  endtask

  task automatic t_short_press();
    int bad = 0;
    @(negedge clk);
    sw = 1'b1;
    repeat (20) @(negedge clk);
    sw = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (out_a != 1'b0 || out_b != 1'b1) bad++;
    end
    check(bad == 0, "R3 short press ignored, cycles driven", bad, 0);
  endtask

  task automatic t_press_follow(input string tag, input bit glitch);
    int d = 0;
    int m_tone = 0, m_mod = 0, m_off = 0, m_inv = 0;
    @(negedge clk);
    sw = 1'b1;
    while (d < 200) begin
      @(negedge clk);
      d++;
      if (out_a != 1'b0) break;
    end
    check(d >= (NSAMP - 1) * P + 1 && d <= NSAMP * P + 3,
          {"R2 ", tag, " activation delay"}, d, NSAMP * P);
    check(out_b == ~out_a, {"R4 ", tag, " active-low switch starts same cycle"}, out_b, !out_a);
    for (int t = 0; t < 1400; t++) begin
      bit e;
      bit on, md;
      if (t > 0) @(negedge clk);
      if (glitch && t == 200) sw = 1'b0;
      if (glitch && t == 220) sw = 1'b1;
      e  = model_drive(t);
      on = (t % (ON_C + OFF_C)) < ON_C;
      md = ((t / MH) % 2) == 0;
      if (out_a != e) begin
        if (!on) m_off++;
        else if (!md) m_mod++;
        else m_tone++;
      end
      if (out_b != !e) m_inv++;
    end
    check(m_tone == 0, {"R5 ", tag, " carrier mismatches"}, m_tone, 0);
    check(m_mod == 0, {"R6 ", tag, " modulation gap mismatches"}, m_mod, 0);
    check(m_off == 0, {"R7 ", tag, " burst off mismatches"}, m_off, 0);
    check(m_inv == 0, {"R9 ", tag, " pnp-polarity mismatches"}, m_inv, 0);
    if (glitch)
      check(m_tone + m_mod + m_off == 0, "R10 release glitch ignored", m_tone + m_mod + m_off, 0);
  endtask

  task automatic t_release();
    int bad = 0;
    @(negedge clk);
    sw = 1'b0;
    repeat (NSAMP * P + 4) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (out_a != 1'b0 || out_b != 1'b1) bad++;
    end
    check(bad == 0, "R8 idle after release, cycles driven", bad, 0);
  endtask

  initial begin
    t_reset();
    t_short_press();
    t_press_follow("first", 1'b1);
    t_release();
    t_press_follow("R8 restart", 1'b0);
    t_release();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chks++;
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

endmodule